// File: doc/BRIEF.md
# Regulator Mode Select Controller

This block decides, once per clock, the operating mode of every regulator in a power-management slice. For the switching regulators it also decides the output voltage code. The inputs are two asynchronous enable pins, a synchronous sleep request, and a small register file. The register file holds a global pin-control enable and, for each regulator, its settings: a software on bit, the pins assigned to it, a keep-on bit and a forced-off bit. For each switching regulator it also holds a roof voltage code and a floor voltage code.

Each linear regulator resolves to active, low-power or off. Each switching regulator resolves to a mode and to one of its two voltage codes. A switching regulator that is controlled by a pin stays active and moves between roof and floor as that pin changes. A sleep request lowers every active resource to low-power unless its keep-on bit holds it at full capability or its forced-off bit turns it off.

The block has no streaming data path. The register port and the control pins are plain signals with no valid/ready handshake: a write takes effect whenever the write strobe is high at a clock edge.

Top module: `regmode_ctrl`

## Requirements
- R1: After reset every mode output is off (2'b00), every voltage output is 0, and every register reads back 0.
- R2: The register map is as follows. Address 0 bit 0 is the pin-control enable. Address 1+i holds the settings of regulator i: bit 0 on, bit 1 assigned to pin A, bit 2 assigned to pin B, bit 3 keep-on, bit 4 forced-off. Address NREG+1+2k is the roof code of switching regulator k and address NREG+2+2k is its floor code. Switching regulators are indices 0..NUM_SW-1. Written values read back zero-extended, and an unmapped address reads 0.
- R3: While pin control is disabled, both pins have no effect. A regulator is active if its on bit is 1 and off otherwise, and a switching regulator then uses its roof code.
- R4: A regulator with neither assignment bit set ignores both pins even while pin control is enabled, and follows its on bit as in R3.
- R5: A switching regulator under pin control is active and outputs its roof code while its assigned pin is high and its floor code while that pin is low.
- R6: A linear regulator under pin control is active while its assigned pin is high. While the pin is low it is low-power if keep-on is 1 and off if keep-on is 0.
- R7: While sleep is requested, a regulator that would otherwise be active becomes low-power, unless R8 applies. A switching regulator keeps its selected voltage code.
- R8: While sleep is requested, a regulator with keep-on set keeps the mode it would have without sleep. A regulator with forced-off set and keep-on clear is off. Keep-on wins when both are set.
- R9: The mode encoding is 2'b00 off, 2'b01 low-power, 2'b10 active, and 2'b11 never appears. A switching regulator that is off outputs voltage code 0.
- R10: Outputs are registered. A register write or a change of sleep shows at the outputs one clock edge later. A pin change passes two synchronizer flops and shows at the outputs on the third clock edge after it is sampled.
- R11: A regulator assigned to both pins treats the request as high when either pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin_a | input | 1 | External enable pin A (asynchronous) |
| en_pin_b | input | 1 | External enable pin B (asynchronous) |
| sleep_req | input | 1 | Global sleep request (synchronous) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational on cfg_addr) |
| mode_o | output | 2*NREG | Mode of regulator i at bits [2i+1:2i] |
| vsel_o | output | VW*NUM_SW | Voltage code of switching regulator k at bits [VW*k+VW-1:VW*k] |

## Verification
A wrong decision in the resolve logic shows as a wrong two-bit mode, or a wrong voltage code, on the affected regulator's slice. It appears exactly one edge after the register or sleep input that provoked it, or three edges after a pin change. A synchronizer with the wrong depth shows at once as an edge that arrives early or late in the latency probe. A corrupted configuration register shows both on read-back and in the mode the regulator takes the next time its inputs select that field.

// File: rtl/regmode_pkg.sv
package regmode_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_LP  = 2'b01,
    MODE_ACT = 2'b10
  } mode_e;

  // Per-regulator settings, LSB first: on, pin A, pin B, keep-on, forced-off
  typedef struct packed {
    logic force_off;
    logic keep;
    logic asg_b;
    logic asg_a;
    logic on;
  } regcfg_t;

  localparam int CFG_W = 5;
endpackage

// File: rtl/regmode_sync.sv
module regmode_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/regmode_regs.sv
module regmode_regs import regmode_pkg::*; #(
  parameter int NREG   = 6,
  parameter int NUM_SW = 2,
  parameter int VW     = 6,
  parameter int DW     = 6,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          pin_en,
  output regcfg_t       cfg   [NREG],
  output logic [VW-1:0] roof  [NUM_SW],
  output logic [VW-1:0] floor [NUM_SW]
);
  localparam int ROOF0 = NREG + 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_en <= 1'b0;
      for (int i = 0; i < NREG; i++) cfg[i] <= '0;
      for (int k = 0; k < NUM_SW; k++) begin
        roof[k]  <= '0;
        floor[k] <= '0;
      end
    end else if (we) begin
      if (addr == '0) pin_en <= wdata[0];
      for (int i = 0; i < NREG; i++)
        if (addr == AW'(1 + i)) cfg[i] <= regcfg_t'(wdata[CFG_W-1:0]);
      for (int k = 0; k < NUM_SW; k++) begin
        if (addr == AW'(ROOF0 + 2*k))     roof[k]  <= wdata[VW-1:0];
        if (addr == AW'(ROOF0 + 2*k + 1)) floor[k] <= wdata[VW-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata[0] = pin_en;
    for (int i = 0; i < NREG; i++)
      if (addr == AW'(1 + i)) rdata[CFG_W-1:0] = cfg[i];
    for (int k = 0; k < NUM_SW; k++) begin
      if (addr == AW'(ROOF0 + 2*k))     rdata[VW-1:0] = roof[k];
      if (addr == AW'(ROOF0 + 2*k + 1)) rdata[VW-1:0] = floor[k];
    end
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == '0) |=> (pin_en == $past(wdata[0]))); // R2
endmodule

// File: rtl/regmode_resolve.sv
module regmode_resolve import regmode_pkg::*; #(
  parameter bit IS_SW = 1'b0
) (
  input  regcfg_t cfg,
  input  logic    pin_en,
  input  logic    pin_a,
  input  logic    pin_b,
  input  logic    sleep,
  output mode_e   mode
);
  logic  pin_ctl, pin_hi;
  mode_e base;

  always_comb begin
    pin_ctl = pin_en & (cfg.asg_a | cfg.asg_b);
    pin_hi  = (cfg.asg_a & pin_a) | (cfg.asg_b & pin_b);
    if (!pin_ctl)             base = cfg.on ? MODE_ACT : MODE_OFF;
    else if (pin_hi || IS_SW) base = MODE_ACT;
    else                      base = cfg.keep ? MODE_LP : MODE_OFF;

    if (!sleep || cfg.keep)   mode = base;
    else if (cfg.force_off)   mode = MODE_OFF;
    else if (base == MODE_ACT) mode = MODE_LP;
    else                      mode = base;
  end
endmodule

// File: rtl/regmode_vsel.sv
module regmode_vsel import regmode_pkg::*; #(
  parameter int VW = 6
) (
  input  logic          asg_a,
  input  logic          asg_b,
  input  logic          pin_en,
  input  logic          pin_a,
  input  logic          pin_b,
  input  mode_e         mode,
  input  logic [VW-1:0] roof,
  input  logic [VW-1:0] floor,
  output logic [VW-1:0] vsel
);
  logic use_floor;

  always_comb begin
    use_floor = pin_en & (asg_a | asg_b) & ~((asg_a & pin_a) | (asg_b & pin_b));
    if (mode == MODE_OFF) vsel = '0;
    else                  vsel = use_floor ? floor : roof;
  end
endmodule

// File: rtl/regmode_ctrl.sv
module regmode_ctrl import regmode_pkg::*; #(
  parameter int NUM_SW  = 2,
  parameter int NUM_LIN = 4,
  parameter int VW      = 6,
  localparam int NREG   = NUM_SW + NUM_LIN,
  localparam int DW     = (VW > CFG_W) ? VW : CFG_W,
  localparam int AW     = $clog2(NREG + 1 + 2*NUM_SW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_pin_a,
  input  logic                 en_pin_b,
  input  logic                 sleep_req,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [DW-1:0]        cfg_wdata,
  output logic [DW-1:0]        cfg_rdata,
  output logic [2*NREG-1:0]    mode_o,
  output logic [VW*NUM_SW-1:0] vsel_o
);
  logic [1:0]    pins_s;
  logic          pin_en;
  regcfg_t       cfg   [NREG];
  logic [VW-1:0] roof  [NUM_SW];
  logic [VW-1:0] floor [NUM_SW];
  mode_e         mode_c [NREG];
  logic [VW-1:0] vsel_c [NUM_SW];
  logic [NREG-1:0][1:0]    mode_q;
  logic [NUM_SW-1:0][VW-1:0] vsel_q;

  regmode_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({en_pin_b, en_pin_a}), .q(pins_s));

  regmode_regs #(.NREG(NREG), .NUM_SW(NUM_SW), .VW(VW), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .pin_en(pin_en), .cfg(cfg), .roof(roof), .floor(floor));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    regmode_resolve #(.IS_SW(i < NUM_SW)) u_res (
      .cfg(cfg[i]), .pin_en(pin_en), .pin_a(pins_s[0]), .pin_b(pins_s[1]),
      .sleep(sleep_req), .mode(mode_c[i]));

    AST_NO_ILLEGAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[i] != 2'b11); // R9
    AST_SLEEP_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_req && cfg[i].force_off && !cfg[i].keep) |=> mode_q[i] == MODE_OFF); // R8
    AST_SLEEP_KEEP_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_req && cfg[i].keep && cfg[i].on && !pin_en) |=> mode_q[i] == MODE_ACT); // R8
    AST_REG_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_en && !sleep_req) |=> mode_q[i] == ($past(cfg[i].on) ? MODE_ACT : MODE_OFF)); // R3
  end

  for (genvar k = 0; k < NUM_SW; k++) begin : g_sw
    regmode_vsel #(.VW(VW)) u_vsel (
      .asg_a(cfg[k].asg_a), .asg_b(cfg[k].asg_b), .pin_en(pin_en),
      .pin_a(pins_s[0]), .pin_b(pins_s[1]), .mode(mode_c[k]),
      .roof(roof[k]), .floor(floor[k]), .vsel(vsel_c[k]));

    AST_OFF_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[k] == MODE_OFF) |-> (vsel_q[k] == '0)); // R9
    AST_SW_NO_PIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_en && (cfg[k].asg_a || cfg[k].asg_b) && !sleep_req) |=> mode_q[k] == MODE_ACT); // R5
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      vsel_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)   mode_q[i] <= mode_c[i];
      for (int k = 0; k < NUM_SW; k++) vsel_q[k] <= vsel_c[k];
    end
  end

  assign mode_o = mode_q;
  assign vsel_o = vsel_q;
endmodule

// File: tb/sim_regmode_ctrl.sv
`timescale 1ns/1ps
module sim_regmode_ctrl;
  localparam int NUM_SW = 2, NUM_LIN = 4, VW = 6;
  localparam int NREG = NUM_SW + NUM_LIN;
  localparam int DW = 6, AW = 4;
  localparam int ROOF0 = NREG + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_pin_a = 1'b0, en_pin_b = 1'b0, sleep_req = 1'b0, cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic [2*NREG-1:0] mode_o;
  logic [VW*NUM_SW-1:0] vsel_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench copy of programmed state
  bit         ctl_en = 1'b0;
  logic [4:0] cfg_sh [NREG];
  logic [5:0] roof_sh [NUM_SW];
  logic [5:0] floor_sh [NUM_SW];

  always #2.5 clk = ~clk;

  regmode_ctrl #(.NUM_SW(NUM_SW), .NUM_LIN(NUM_LIN), .VW(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .en_pin_a(en_pin_a), .en_pin_b(en_pin_b),
    .sleep_req(sleep_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mode_o(mode_o), .vsel_o(vsel_o));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] m_mode(int i, bit pa, bit pb, bit sl);
    logic [4:0] c;
    bit pc, hi;
    logic [1:0] b;
    c  = cfg_sh[i];
    pc = ctl_en && (c[1] || c[2]);
    hi = (c[1] && pa) || (c[2] && pb);
    if (!pc)                b = c[0] ? 2'b10 : 2'b00;
    else if (hi || i < NUM_SW) b = 2'b10;
    else                    b = c[3] ? 2'b01 : 2'b00;
    if (sl && !c[3]) begin
      if (c[4])            b = 2'b00;
      else if (b == 2'b10) b = 2'b01;
    end
    return b;
  endfunction

  function automatic logic [5:0] m_vsel(int k, bit pa, bit pb, bit sl);
    logic [4:0] c;
    bit pc, hi;
    c  = cfg_sh[k];
    pc = ctl_en && (c[1] || c[2]);
    hi = (c[1] && pa) || (c[2] && pb);
    if (m_mode(k, pa, pb, sl) == 2'b00) return 6'd0;
    return (pc && !hi) ? floor_sh[k] : roof_sh[k];
  endfunction

  task automatic wr(int a, logic [5:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 0) ctl_en = d[0];
    else if (a <= NREG) cfg_sh[a-1] = d[4:0];
    else if (a < ROOF0 + 2*NUM_SW) begin
      if (((a - ROOF0) % 2) == 0) roof_sh[(a-ROOF0)/2] = d;
      else                        floor_sh[(a-ROOF0)/2] = d;
    end
  endtask

  task automatic rd(int a, output logic [5:0] d);
    @(negedge clk);
    cfg_addr = AW'(a);
    #1 d = cfg_rdata;
  endtask

  task automatic drive(bit pa, bit pb, bit sl);
    @(negedge clk);
    en_pin_a = pa; en_pin_b = pb; sleep_req = sl;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < NREG; i++)
      chk(tag, 32'(mode_o[2*i +: 2]), 32'(m_mode(i, en_pin_a, en_pin_b, sleep_req)));
    for (int k = 0; k < NUM_SW; k++)
      chk(tag, 32'(vsel_o[VW*k +: VW]), 32'(m_vsel(k, en_pin_a, en_pin_b, sleep_req)));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] d;
    void'($urandom(32'd4711));
    for (int i = 0; i < NREG; i++) cfg_sh[i] = '0;
    for (int k = 0; k < NUM_SW; k++) begin roof_sh[k] = '0; floor_sh[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 modes", 32'(mode_o), 32'd0);
    chk("R1 vsel", 32'(vsel_o), 32'd0);
    for (int a = 0; a < ROOF0 + 2*NUM_SW; a++) begin
      rd(a, d); chk("R1 readback", 32'(d), 32'd0);
    end

    // R2 write and read back
    wr(0, 6'h3F); rd(0, d); chk("R2 ctrl", 32'(d), 32'd1);
    wr(3, 6'h3F); rd(3, d); chk("R2 cfg", 32'(d), 32'h1F);
    wr(ROOF0 + 3, 6'h2A); rd(ROOF0 + 3, d); chk("R2 floor1", 32'(d), 32'h2A);
    rd(ROOF0 + 2*NUM_SW, d); chk("R2 unmapped", 32'(d), 32'd0);

    // R3 register control, pins ignored
    wr(0, 0); wr(1, 6'b00111); wr(3, 6'b00111); wr(ROOF0, 6'd17); wr(ROOF0 + 1, 6'd3);
    drive(1, 1, 0); check_all("R3 pins high");
    chk("R3 sw roof", 32'(vsel_o[5:0]), 32'd17);
    drive(0, 0, 0); check_all("R3 pins low");
    chk("R3 lin on", 32'(mode_o[5:4]), 32'd2);

    // R4 unassigned regulator ignores pins under pin control
    wr(0, 1); wr(4, 6'b00001);
    drive(0, 0, 0); chk("R4 unassigned", 32'(mode_o[7:6]), 32'd2);
    drive(1, 1, 0); chk("R4 unassigned", 32'(mode_o[7:6]), 32'd2);

    // R5 and R10 switching regulator roof/floor with pin latency
    wr(1, 6'b00010); wr(ROOF0, 6'd5); wr(ROOF0 + 1, 6'd9);
    drive(0, 0, 0);
    chk("R5 floor", 32'(vsel_o[5:0]), 32'd9);
    chk("R5 active low pin", 32'(mode_o[1:0]), 32'd2);
    @(negedge clk); en_pin_a = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R10 pin not yet", 32'(vsel_o[5:0]), 32'd9);
    @(posedge clk); #1;
    chk("R10 pin third edge", 32'(vsel_o[5:0]), 32'd5);
    // R7 and R10 sleep one edge, voltage kept
    @(negedge clk); sleep_req = 1'b1;
    @(posedge clk); #1;
    chk("R7 sleep lp", 32'(mode_o[1:0]), 32'd1);
    chk("R7 voltage kept", 32'(vsel_o[5:0]), 32'd5);
    // R10 register write one edge
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 4'd1; cfg_wdata = 6'b10010;
    @(posedge clk); #1; cfg_we = 1'b0; cfg_sh[0] = 5'b10010;
    chk("R10 write not yet", 32'(mode_o[1:0]), 32'd1);
    @(posedge clk); #1;
    chk("R10 write next edge", 32'(mode_o[1:0]), 32'd0);
    chk("R9 off code zero", 32'(vsel_o[5:0]), 32'd0);

    // R6 linear regulator under pin control
    wr(3, 6'b01100);
    drive(0, 0, 0); chk("R6 low keep lp", 32'(mode_o[5:4]), 32'd1);
    drive(0, 1, 0); chk("R6 high active", 32'(mode_o[5:4]), 32'd2);
    wr(3, 6'b00100);
    drive(0, 0, 0); chk("R6 low off", 32'(mode_o[5:4]), 32'd0);

    // R11 both pins assigned
    wr(3, 6'b00110);
    drive(0, 1, 0); chk("R11 b only", 32'(mode_o[5:4]), 32'd2);
    drive(1, 0, 0); chk("R11 a only", 32'(mode_o[5:4]), 32'd2);
    drive(0, 0, 0); chk("R11 none", 32'(mode_o[5:4]), 32'd0);

    // R8 keep/force during sleep
    wr(4, 6'b11001); wr(5, 6'b10001); wr(6, 6'b00001);
    drive(0, 0, 1);
    chk("R8 keep wins", 32'(mode_o[7:6]), 32'd2);
    chk("R8 force off", 32'(mode_o[9:8]), 32'd0);
    chk("R7 default lp", 32'(mode_o[11:10]), 32'd1);
    check_all("R8 all");

    // random mix: R3 R4 R5 R6 R7 R8 R9 R11
    for (int it = 0; it < 300; it++) begin
      int nw;
      nw = $urandom_range(0, 3);
      for (int w = 0; w < nw; w++) begin
        int a;
        a = $urandom_range(0, ROOF0 + 2*NUM_SW - 1);
        wr(a, 6'($urandom()));
      end
      drive(1'($urandom()), 1'($urandom()), ($urandom_range(0, 3) == 0));
      check_all("R5 R6 R7 R8 R11 random");
      for (int i = 0; i < NREG; i++)
        chk("R9 legal", 32'(mode_o[2*i +: 2] != 2'b11), 32'd1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule